// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Tags

This block is the receive-side character store of a serial channel. A bit-level receiver hands it each assembled character together with three error flags (parity, framing, break). The block keeps flags and data side by side in one entry. It shows the oldest entry to the host as a read-only holding value, with that entry's flags exposed in a line status field. Popping an entry moves the flags of the next character into view on the following cycle, so the host always sees the flags that belong to the byte it is about to read.

Two interrupt sources are produced. A fill interrupt asserts when the number of stored characters reaches a selectable trigger level. An idle timeout asserts when characters sit in the buffer and nothing is written or read for a span derived from the word length. The timeout is driven by a three-state machine:
- `TO_IDLE`: the buffer is empty.
- `TO_COUNT`: the buffer holds data and the timer is counting bit times.
- `TO_FIRED`: the timeout has expired.

The transitions are:
- *arm*: `TO_IDLE`→`TO_COUNT` on an accepted write.
- *touch*: `TO_COUNT`/`TO_FIRED`→`TO_COUNT` with the timer restarted, on any write or read strobe.
- *expire*: `TO_COUNT`→`TO_FIRED` on the last bit tick of the window.
- *drain*: any state→`TO_IDLE` when the buffer becomes empty or is flushed.

Clearing the buffer-enable input shrinks the store to a single entry and empties it.

Top module: `uart_rx_buffer`

## Requirements
- R1: With `fifo_en`=1 the block stores up to 64 characters and `rd_data` shows the oldest unread one. Writes do not disturb the shown entry.
- R2: Each entry keeps its 3 error tags: `wr_tags[0]`→`lsr_stat[2]`, `[1]`→`[3]`, `[2]`→`[4]`. After a read strobe, the next entry's data and tags appear on the cycle after the strobe edge.
- R3: A write while the buffer is full drops the character, leaves the stored entries intact and sets `lsr_stat[1]` (overrun). A `lsr_rd` pulse clears it.
- R4: A read strobe on an empty buffer moves no pointer, and `rd_data` keeps the last character read.
- R5: `lsr_stat[0]` is 1 exactly when the buffer holds at least one character.
- R6: `irq_data` asserts when `rx_ie`=1 and the fill count is at least the trigger level. `trig_sel` 0/1/2/3 selects 1/16/32/56. With `fifo_en`=0 the level is 1.
- R7: `irq_timeout` asserts when `rx_ie`=1, the buffer is non-empty and no write or read has occurred for 4×(5+`word_len`)+12 bit times. A bit time is 16 `sample_tick` pulses (`os8`=0) or 8 (`os8`=1). The flag appears exactly that many ticks after the last write or read edge.
- R8: Any write or read strobe restarts the timeout and clears a fired timeout. An empty buffer never times out.
- R9: With `fifo_en`=0 the buffer holds one character; a second write overruns.
- R10: Driving `fifo_en` from 1 to 0 empties the buffer on the next edge.
- R11: With `rx_ie`=0 both interrupt outputs stay 0.
- R12: After reset the buffer is empty, and `rd_data`, `lsr_stat`, `irq_data` and `irq_timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 64-entry buffer; 0: single entry; falling edge flushes |
| rx_ie | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Fill trigger select (1/16/32/56) |
| word_len | input | 2 | Data bits minus 5 |
| os8 | input | 1 | 1: 8 ticks per bit; 0: 16 ticks per bit |
| sample_tick | input | 1 | Oversampling clock enable |
| wr_valid | input | 1 | Character from shift register |
| wr_data | input | 8 | Character data |
| wr_tags | input | 3 | Error tags of the character |
| rd_strobe | input | 1 | Host read of holding value |
| lsr_rd | input | 1 | Host read of line status (clears overrun) |
| rd_data | output | 8 | Holding value |
| lsr_stat | output | 5 | {tags, overrun, data ready} |
| irq_data | output | 1 | Fill trigger interrupt |
| irq_timeout | output | 1 | Idle timeout interrupt |

## Verification
The assertions watch, on every cycle, several invariants:
- The shown entry stays stable until it is popped.
- A full-buffer write raises overrun.
- An empty read moves nothing.
- A flush empties the store.
- The single-entry mode never holds two characters.
- A write or read never leaves the timer fired.
- The timeout never rises without a bit tick, and never fires while empty.

Only the bench scenarios can show the rest: the exact FIFO order and tag pairing across 64 entries, the exact trigger counts, and the exact expiry cycle for two word-length and oversampling settings.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;

    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             wr_valid,
    input  rx_entry_t        wr_entry,
    input  logic             rd_strobe,
    input  logic             ovr_clr,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             overrun,
    output logic             push,
    output logic             going_empty
);
    logic              fifo_en_q;
    logic              flush;
    logic              full;
    logic              pop;
    logic [CNT_W-1:0]  cap;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] last_q;
    rx_entry_t         mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        flush       = fifo_en_q & ~fifo_en;
        cap         = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full        = (count >= cap);
        push        = wr_valid & ~full & ~flush;
        pop         = rd_strobe & (count != '0) & ~flush;
        going_empty = flush | (pop & ~push & (count == CNT_W'(1)));
        if (count != '0) begin
            head = mem[rd_ptr];
        end else begin
            head.tags = '0;
            head.data = last_q;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            last_q    <= '0;
            overrun   <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (push) begin
                    wr_ptr <= bump(wr_ptr);
                end
                if (pop) begin
                    rd_ptr <= bump(rd_ptr);
                    last_q <= mem[rd_ptr].data;
                end
                unique case ({push, pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
            if (wr_valid && full && !flush) begin
                overrun <= 1'b1;
            end else if (ovr_clr) begin
                overrun <= 1'b0;
            end
        end
    end

    // R1: the shown entry only changes when it is popped or flushed
    p_head_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !pop && !flush) |=> head == $past(head));

    // R3: a write into a full store raises overrun
    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !flush) |=> overrun);

    // R4: a read from an empty store moves nothing
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && count == '0 && !wr_valid) |=> ($stable(rd_ptr) && head.data == $past(head.data)));

    // R10: a flush leaves the store empty
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);

    // R9: single-entry mode never holds two characters
    p_single_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !fifo_en_q) |-> count <= CNT_W'(1));
endmodule

// File: rtl/rxbuf_trigger.sv
module rxbuf_trigger #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    output logic             level_hit
);
    localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL_QTR  = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] LVL_NEAR = CNT_W'(DEPTH - 8);

    logic [CNT_W-1:0] level;

    always_comb begin
        if (!fifo_en) begin
            level = LVL_ONE;
        end else begin
            unique case (trig_sel)
                2'd0:    level = LVL_ONE;
                2'd1:    level = LVL_QTR;
                2'd2:    level = LVL_HALF;
                default: level = LVL_NEAR;
            endcase
        end
        level_hit = (count >= level);
    end
endmodule

// File: rtl/rxbuf_timeout.sv
module rxbuf_timeout
    import uart_rxbuf_pkg::*;
#(
    parameter int OS_SLOW    = 16,
    parameter int OS_FAST    = 8,
    parameter int CHAR_BASE  = 5,
    parameter int TO_CHARS   = 4,
    parameter int GUARD_BITS = 12,
    localparam int OS_W  = $clog2(OS_SLOW),
    localparam int LIM_W = $clog2(TO_CHARS * (CHAR_BASE + 3) + GUARD_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       os8,
    input  logic [1:0] word_len,
    input  logic       arm,
    input  logic       touch,
    input  logic       drain,
    output logic       fired
);
    to_state_t         state_q;
    to_state_t         state_d;
    logic [OS_W-1:0]   os_cnt;
    logic [OS_W-1:0]   os_term;
    logic [LIM_W-1:0]  bit_cnt;
    logic [LIM_W-1:0]  limit;
    logic              bit_tick;
    logic              expire;
    logic              run;

    always_comb begin
        limit    = LIM_W'(TO_CHARS * CHAR_BASE + GUARD_BITS) + LIM_W'(TO_CHARS) * LIM_W'(word_len);
        os_term  = os8 ? OS_W'(OS_FAST - 1) : OS_W'(OS_SLOW - 1);
        bit_tick = sample_tick && (os_cnt == os_term);
        expire   = bit_tick && (bit_cnt == limit - 1'b1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TO_IDLE: begin
                if (arm && !drain) state_d = TO_COUNT;
            end
            TO_COUNT: begin
                if (drain)       state_d = TO_IDLE;
                else if (touch)  state_d = TO_COUNT;
                else if (expire) state_d = TO_FIRED;
            end
            TO_FIRED: begin
                if (drain)      state_d = TO_IDLE;
                else if (touch) state_d = TO_COUNT;
            end
            default: state_d = TO_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TO_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fired = (state_q == TO_FIRED);
        run   = (state_q == TO_COUNT) && !touch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
        end else if (sample_tick) begin
            if (os_cnt == os_term) begin
                os_cnt  <= '0;
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                os_cnt <= os_cnt + 1'b1;
            end
        end
    end

    // R8: activity never leaves the timer in the fired state
    p_touch_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> state_q != TO_FIRED);

    // R7: expiry only happens on a bit-time boundary
    p_fire_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> $past(bit_tick));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int OS_SLOW = 16,
    parameter int OS_FAST = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_ie,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              os8,
    input  logic              sample_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tags,
    input  logic              rd_strobe,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [4:0]        lsr_stat,
    output logic              irq_data,
    output logic              irq_timeout
);
    rx_entry_t        wr_entry;
    rx_entry_t        head;
    logic [CNT_W-1:0] count;
    logic             overrun;
    logic             push;
    logic             going_empty;
    logic             level_hit;
    logic             to_fired;

    always_comb begin
        wr_entry.data = wr_data;
        wr_entry.tags = wr_tags;
    end

    rxbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .wr_valid    (wr_valid),
        .wr_entry    (wr_entry),
        .rd_strobe   (rd_strobe),
        .ovr_clr     (lsr_rd),
        .head        (head),
        .count       (count),
        .overrun     (overrun),
        .push        (push),
        .going_empty (going_empty)
    );

    rxbuf_trigger #(.DEPTH(DEPTH)) u_trig (
        .fifo_en   (fifo_en),
        .trig_sel  (trig_sel),
        .count     (count),
        .level_hit (level_hit)
    );

    rxbuf_timeout #(.OS_SLOW(OS_SLOW), .OS_FAST(OS_FAST)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .os8         (os8),
        .word_len    (word_len),
        .arm         (push),
        .touch       (wr_valid | rd_strobe),
        .drain       (going_empty),
        .fired       (to_fired)
    );

    always_comb begin
        rd_data     = head.data;
        lsr_stat    = {head.tags, overrun, (count != '0)};
        irq_data    = rx_ie & level_hit;
        irq_timeout = rx_ie & to_fired;
    end

    // R8: an empty buffer never has a fired timeout
    p_no_timeout_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !to_fired);
endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_ie = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] word_len = 2'd0;
    logic       os8 = 1'b0;
    logic       sample_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] wr_tags = 3'd0;
    logic       rd_strobe = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] lsr_stat;
    logic       irq_data;
    logic       irq_timeout;

    int n_tests = 0;
    int n_fail = 0;
    logic [10:0] exp_q[$];
    logic [7:0]  last_data = 8'd0;

    always #2 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_ie(rx_ie),
        .trig_sel(trig_sel), .word_len(word_len), .os8(os8),
        .sample_tick(sample_tick), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_tags(wr_tags), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
        .rd_data(rd_data), .lsr_stat(lsr_stat), .irq_data(irq_data),
        .irq_timeout(irq_timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: presents one character and records what should come out
    task automatic push_char(input logic [7:0] d, input logic [2:0] t);
        wr_valid = 1'b1; wr_data = d; wr_tags = t;
        @(negedge clk);
        wr_valid = 1'b0;
        if (exp_q.size() < (fifo_en ? 64 : 1)) exp_q.push_back({t, d});
    endtask

    // monitor: compares the shown entry against the scoreboard, then pops
    task automatic read_one(input string req);
        logic [10:0] e;
        if (exp_q.size() == 0) begin
            chk(req, 32'(rd_data), 32'(last_data));
        end else begin
            e = exp_q.pop_front();
            chk(req, 32'(rd_data), 32'(e[7:0]));
            chk("R2 tags", 32'(lsr_stat[4:2]), 32'(e[10:8]));
            last_data = e[7:0];
        end
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 rd_data", 32'(rd_data), 0);
        chk("R12 lsr", 32'(lsr_stat), 0);
        chk("R12 irq_data", 32'(irq_data), 0);
        chk("R12 irq_timeout", 32'(irq_timeout), 0);

        // R1/R2/R6: 20 characters, trigger at 16
        fifo_en = 1'b1; rx_ie = 1'b1; trig_sel = 2'd1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            push_char(8'h30 + 8'(i), 3'(i));
            if (i == 14) chk("R6 below 16", 32'(irq_data), 0);
            if (i == 15) chk("R6 at 16", 32'(irq_data), 1);
        end
        chk("R5 ready", 32'(lsr_stat[0]), 1);
        for (int i = 0; i < 20; i++) read_one("R1 order");
        chk("R5 empty", 32'(lsr_stat[0]), 0);
        chk("R6 drained", 32'(irq_data), 0);

        // R4: read on empty keeps the last value
        read_one("R4 empty read");
        chk("R4 still empty", 32'(lsr_stat[0]), 0);
        push_char(8'hA5, 3'd5);
        read_one("R4 after empty read");

        // R3/R6: fill to 64, trigger at 56, then overrun
        trig_sel = 2'd3;
        for (int i = 0; i < 64; i++) begin
            push_char(8'(i) ^ 8'h5A, 3'((i + 3) % 8));
            if (i == 54) chk("R6 below 56", 32'(irq_data), 0);
            if (i == 55) chk("R6 at 56", 32'(irq_data), 1);
        end
        chk("R3 no overrun yet", 32'(lsr_stat[1]), 0);
        push_char(8'hEE, 3'd7);
        chk("R3 overrun", 32'(lsr_stat[1]), 1);
        for (int i = 0; i < 64; i++) read_one("R3 contents");
        chk("R3 dropped char absent", 32'(lsr_stat[0]), 0);
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
        chk("R3 overrun cleared", 32'(lsr_stat[1]), 0);

        // R7: word_len 0, 8 ticks per bit -> 32 bits -> 256 cycles
        trig_sel = 2'd0; word_len = 2'd0; os8 = 1'b1; sample_tick = 1'b1;
        push_char(8'h11, 3'd1);
        repeat (255) @(posedge clk);
        @(negedge clk);
        chk("R7 not yet", 32'(irq_timeout), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 fired", 32'(irq_timeout), 1);
        chk("R6 level one", 32'(irq_data), 1);
        rx_ie = 1'b0;
        #1;
        chk("R11 timeout masked", 32'(irq_timeout), 0);
        chk("R11 data masked", 32'(irq_data), 0);
        rx_ie = 1'b1;
        @(negedge clk);
        read_one("R8 read clears");
        chk("R8 cleared", 32'(irq_timeout), 0);
        repeat (800) @(negedge clk);
        chk("R8 empty never fires", 32'(irq_timeout), 0);

        // R7/R8: word_len 3, 16 ticks per bit -> 44 bits -> 704 cycles, restarted
        word_len = 2'd3; os8 = 1'b0;
        push_char(8'h22, 3'd2);
        repeat (400) @(negedge clk);
        push_char(8'h33, 3'd3);
        repeat (703) @(posedge clk);
        @(negedge clk);
        chk("R8 restart held off", 32'(irq_timeout), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 fired 44 bits", 32'(irq_timeout), 1);
        sample_tick = 1'b0;

        // R10: clearing fifo_en flushes
        fifo_en = 1'b0;
        @(negedge clk);
        exp_q.delete();
        chk("R10 flushed", 32'(lsr_stat[0]), 0);
        chk("R10 timeout dropped", 32'(irq_timeout), 0);

        // R9: single-entry mode
        trig_sel = 2'd3;
        push_char(8'h44, 3'd1);
        chk("R6 level one when disabled", 32'(irq_data), 1);
        push_char(8'h55, 3'd2);
        chk("R9 second write overruns", 32'(lsr_stat[1]), 1);
        read_one("R9 first kept");
        chk("R9 empty after one read", 32'(lsr_stat[0]), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule